// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two entries from a page table held in memory. A root register names the first-level directory. The upper index field of the address picks a directory entry. That entry names a second-level table. The middle index field picks an entry in that table. The entry gives the frame number, and the walker joins the frame number to the untouched page offset.

The requester side has a request channel and a response channel, and both use valid/ready handshakes. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the walker is idle, so only one walk is ever in progress. The response is held steady from the first cycle `rsp_valid` is high until the edge where `rsp_ready` is also high. On the memory side the walker raises `mem_rd_valid` with an address and holds both until `mem_rd_ready` accepts them. The memory then returns one word, marked by a one-cycle `mem_rdata_valid`, in a later cycle. Only one read is outstanding at any time.

When either entry has its valid bit clear, the walk ends with a fault response. The response reports which of the two levels failed.

Top module: `ptw_walker`

## Requirements
- R1: While reset is asserted and after it is released, the walker is idle: `req_ready`=1, `rsp_valid`=0 and `mem_rd_valid`=0.
- R2: The first read address is the root sampled at acceptance plus 4 times vaddr[31:22].
- R3: The second read address is the directory entry's bits 31:12 followed by 12 zero bits, plus 4 times vaddr[21:12].
- R4: When both entries are valid (entry bit 0 = 1), the response has `rsp_fault`=0 and `rsp_paddr` = {page-table entry bits 31:12, vaddr[11:0]}.
- R5: A directory entry with bit 0 = 0 ends the walk after exactly one read. The response has `rsp_fault`=1, `rsp_fault_lvl`=0 and `rsp_paddr`=0.
- R6: A page-table entry with bit 0 = 0 ends the walk after two reads. The response has `rsp_fault`=1, `rsp_fault_lvl`=1 and `rsp_paddr`=0.
- R7: `req_ready` is low from the acceptance edge until the response handshake. A request held valid during that time is not taken, and the walk in progress is not disturbed.
- R8: Changes to `table_root` or `req_vaddr` after acceptance do not change the walk's read addresses or its result.
- R9: A read request is held with a stable address until `mem_rd_ready` accepts it.
- R10: The response is held with a stable payload until `rsp_ready` accepts it.
- R11: No new read is issued while returned data is still awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| table_root | input | 32 | Byte address of the first-level directory |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_paddr | output | 32 | Physical address, or 0 on a fault |
| rsp_fault | output | 1 | Walk ended on an invalid entry |
| rsp_fault_lvl | output | 1 | Failing level: 0 directory, 1 page table |
| mem_rd_valid | output | 1 | Memory read request valid |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rdata_valid | input | 1 | Returned entry is valid this cycle |
| mem_rdata | input | 32 | Returned entry word |

## Verification
The assertions assume that the memory never returns data unless a read was accepted in an earlier cycle, and that it returns exactly one word for each accepted read. The bench's memory model keeps to this rule. It accepts a read only when no data is still pending, and after each accepted read it returns one word after a random delay of one to three cycles. It also withholds `mem_rd_ready` at random, the requester withholds `rsp_ready` at random, and the root and address inputs are scrambled after each request is accepted. Entry contents are a hash of the entry address, with the valid bit forced low in the directed and random fault cases.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    IDLE,
    READ_DIR,
    WAIT_DIR,
    READ_PTE,
    WAIT_PTE,
    RESPOND
  } walk_state_e;

  localparam int unsigned ENTRY_VALID_BIT = 0;
  localparam int unsigned ENTRY_BYTES_LOG2 = 2;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int unsigned AW    = 32,
  parameter int unsigned DIR_W = 10,
  parameter int unsigned TBL_W = 10,
  parameter int unsigned OFF_W = 12
) (
  input  logic [AW-1:0]       root,
  input  logic [AW-1:0]       vaddr,
  input  logic [AW-OFF_W-1:0] tbl_frame,
  input  logic                second_level,
  output logic [AW-1:0]       entry_addr
);
  import ptw_pkg::*;

  localparam int unsigned IDX_W = (DIR_W > TBL_W) ? DIR_W : TBL_W;

  logic [IDX_W-1:0] dir_idx;
  logic [IDX_W-1:0] tbl_idx;
  logic [AW-1:0]    level_base;
  logic [AW-1:0]    scaled_idx;

  assign dir_idx = IDX_W'(vaddr[AW-1 -: DIR_W]);
  assign tbl_idx = IDX_W'(vaddr[OFF_W +: TBL_W]);

  always_comb begin
    if (second_level) begin
      level_base = {tbl_frame, {OFF_W{1'b0}}};
      scaled_idx = AW'(tbl_idx) << ENTRY_BYTES_LOG2;
    end else begin
      level_base = root;
      scaled_idx = AW'(dir_idx) << ENTRY_BYTES_LOG2;
    end
  end

  assign entry_addr = level_base + scaled_idx;
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_fire,
  input  logic                 rd_ready,
  input  logic                 rdata_valid,
  input  logic                 entry_ok,
  input  logic                 rsp_ready,
  output ptw_pkg::walk_state_e state
);
  import ptw_pkg::*;

  walk_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      IDLE:     if (req_fire)    nxt = READ_DIR;
      READ_DIR: if (rd_ready)    nxt = WAIT_DIR;
      WAIT_DIR: if (rdata_valid) nxt = entry_ok ? READ_PTE : RESPOND;
      READ_PTE: if (rd_ready)    nxt = WAIT_PTE;
      WAIT_PTE: if (rdata_valid) nxt = RESPOND;
      RESPOND:  if (rsp_ready)   nxt = IDLE;
      default:                   nxt = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int unsigned AW    = 32,
  parameter int unsigned DIR_W = 10,
  parameter int unsigned TBL_W = 10,
  parameter int unsigned OFF_W = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_vaddr,
  input  logic [AW-1:0] table_root,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [AW-1:0] rsp_paddr,
  output logic          rsp_fault,
  output logic          rsp_fault_lvl,
  output logic          mem_rd_valid,
  input  logic          mem_rd_ready,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rdata_valid,
  input  logic [AW-1:0] mem_rdata
);
  import ptw_pkg::*;

  localparam int unsigned FRAME_W = AW - OFF_W;

  walk_state_e        state;
  logic               req_fire;
  logic               entry_ok;
  logic               second_level;
  logic [AW-1:0]      vaddr_q;
  logic [AW-1:0]      root_q;
  logic [FRAME_W-1:0] tbl_frame_q;
  logic [AW-1:0]      paddr_q;
  logic               fault_q;
  logic               lvl_q;

  assign req_fire     = req_valid && req_ready;
  assign entry_ok     = mem_rdata[ENTRY_VALID_BIT];
  assign second_level = (state == READ_PTE) || (state == WAIT_PTE);

  ptw_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_fire    (req_fire),
    .rd_ready    (mem_rd_ready),
    .rdata_valid (mem_rdata_valid),
    .entry_ok    (entry_ok),
    .rsp_ready   (rsp_ready),
    .state       (state)
  );

  ptw_addr_gen #(
    .AW    (AW),
    .DIR_W (DIR_W),
    .TBL_W (TBL_W),
    .OFF_W (OFF_W)
  ) u_addr (
    .root         (root_q),
    .vaddr        (vaddr_q),
    .tbl_frame    (tbl_frame_q),
    .second_level (second_level),
    .entry_addr   (mem_rd_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vaddr_q     <= '0;
      root_q      <= '0;
      tbl_frame_q <= '0;
      paddr_q     <= '0;
      fault_q     <= 1'b0;
      lvl_q       <= 1'b0;
    end else begin
      if (req_fire) begin
        vaddr_q <= req_vaddr;
        root_q  <= table_root;
      end
      if (state == WAIT_DIR && mem_rdata_valid) begin
        if (entry_ok) begin
          tbl_frame_q <= mem_rdata[AW-1:OFF_W];
        end else begin
          paddr_q <= '0;
          fault_q <= 1'b1;
          lvl_q   <= 1'b0;
        end
      end
      if (state == WAIT_PTE && mem_rdata_valid) begin
        if (entry_ok) begin
          paddr_q <= {mem_rdata[AW-1:OFF_W], vaddr_q[OFF_W-1:0]};
          fault_q <= 1'b0;
          lvl_q   <= 1'b0;
        end else begin
          paddr_q <= '0;
          fault_q <= 1'b1;
          lvl_q   <= 1'b1;
        end
      end
    end
  end

  assign req_ready     = (state == IDLE);
  assign mem_rd_valid  = (state == READ_DIR) || (state == READ_PTE);
  assign rsp_valid     = (state == RESPOND);
  assign rsp_paddr     = paddr_q;
  assign rsp_fault     = fault_q;
  assign rsp_fault_lvl = lvl_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int unsigned AW    = 32,
  parameter int unsigned OFF_W = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_vaddr,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [AW-1:0] rsp_paddr,
  input logic          rsp_fault,
  input logic          rsp_fault_lvl,
  input logic          mem_rd_valid,
  input logic          mem_rd_ready,
  input logic [AW-1:0] mem_rd_addr,
  input logic          mem_rdata_valid
);
  logic             pending;
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      off_q   <= '0;
    end else begin
      if (mem_rd_valid && mem_rd_ready) pending <= 1'b1;
      else if (mem_rdata_valid)         pending <= 1'b0;
      if (req_valid && req_ready)       off_q   <= req_vaddr[OFF_W-1:0];
    end
  end

  p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rsp_valid && !mem_rd_valid));

  p_offset_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == off_q));

  p_fault_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

  p_busy_no_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault) && $stable(rsp_fault_lvl)));

  p_one_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !mem_rd_valid);
endmodule

bind ptw_walker ptw_walker_chk #(.AW(AW), .OFF_W(OFF_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .req_ready       (req_ready),
  .req_vaddr       (req_vaddr),
  .rsp_valid       (rsp_valid),
  .rsp_ready       (rsp_ready),
  .rsp_paddr       (rsp_paddr),
  .rsp_fault       (rsp_fault),
  .rsp_fault_lvl   (rsp_fault_lvl),
  .mem_rd_valid    (mem_rd_valid),
  .mem_rd_ready    (mem_rd_ready),
  .mem_rd_addr     (mem_rd_addr),
  .mem_rdata_valid (mem_rdata_valid)
);

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic [31:0] table_root;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic        rsp_fault_lvl;
  logic        mem_rd_valid;
  logic        mem_rd_ready;
  logic [31:0] mem_rd_addr;
  logic        mem_rdata_valid;
  logic [31:0] mem_rdata;

  int          n_chk = 0;
  int          n_bad = 0;
  int          rd_count;
  logic [31:0] rd_log [4];
  logic [31:0] pend_addr;
  int          pend;
  bit          stalled;
  logic [31:0] stall_addr;
  bit          dir_bad;
  bit          pte_bad;
  bit          finished = 0;

  always #5 clk = ~clk;

  ptw_walker dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .table_root(table_root),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_fault_lvl(rsp_fault_lvl),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rdata_valid(mem_rdata_valid), .mem_rdata(mem_rdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [31:0] a, input bit ok);
    logic [31:0] h;
    h = (a * 32'h9E3779B1) ^ (a >> 11) ^ 32'h5A5A_0000;
    return {h[31:12], 11'd0, ok};
  endfunction

  // Memory model: one read outstanding, data 1..3 cycles after acceptance
  initial begin
    mem_rd_ready = 0; mem_rdata_valid = 0; mem_rdata = '0;
    pend = 0; stalled = 0; stall_addr = '0; pend_addr = '0; rd_count = 0;
    forever begin
      @(negedge clk);
      mem_rdata_valid = 0;
      mem_rd_ready = 0;
      if (pend > 0) begin
        check(!mem_rd_valid, "R11 read while data pending", {31'd0, mem_rd_valid}, 32'd0);
        pend--;
        if (pend == 0) begin
          mem_rdata_valid = 1;
          mem_rdata = mem_word(pend_addr, (rd_count == 1) ? !dir_bad : !pte_bad);
        end
      end else if (mem_rd_valid) begin
        if (stalled)
          check(mem_rd_addr == stall_addr, "R9 address held under stall", mem_rd_addr, stall_addr);
        if (($urandom % 3) != 0) begin
          mem_rd_ready = 1;
          pend_addr = mem_rd_addr;
          if (rd_count < 4) rd_log[rd_count] = mem_rd_addr;
          rd_count++;
          pend = 1 + int'($urandom % 3);
          stalled = 0;
        end else begin
          stalled = 1;
          stall_addr = mem_rd_addr;
        end
      end else if (stalled && rst_n) begin
        check(0, "R9 read dropped under stall", 32'd0, 32'd1);
        stalled = 0;
      end
    end
  end

  task automatic run_walk(input logic [31:0] va, input logic [31:0] root,
                          input bit dbad, input bit pbad, input bit hold_req);
    logic [31:0] e_dir_addr, e_dir, e_pte_addr, e_pte, e_pa;
    bit          e_fault, e_lvl;
    int          e_reads;
    e_dir_addr = root + {20'd0, va[31:22], 2'b00};
    e_dir      = mem_word(e_dir_addr, !dbad);
    e_pte_addr = {e_dir[31:12], 12'd0} + {20'd0, va[21:12], 2'b00};
    e_pte      = mem_word(e_pte_addr, !pbad);
    if (dbad) begin
      e_fault = 1; e_lvl = 0; e_pa = '0; e_reads = 1;
    end else if (pbad) begin
      e_fault = 1; e_lvl = 1; e_pa = '0; e_reads = 2;
    end else begin
      e_fault = 0; e_lvl = 0; e_pa = {e_pte[31:12], va[11:0]}; e_reads = 2;
    end

    @(negedge clk);
    dir_bad = dbad; pte_bad = pbad; rd_count = 0;
    table_root = root; req_vaddr = va; req_valid = 1;
    check(req_ready, "R7 ready when idle", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    if (!hold_req) req_valid = 0;
    table_root = $urandom;   // R8: scrambled after acceptance
    req_vaddr  = $urandom;
    while (!rsp_valid) begin
      check(!req_ready, "R7 busy not ready", {31'd0, req_ready}, 32'd0);
      @(negedge clk);
    end
    forever begin
      check(rsp_valid, "R10 response held", {31'd0, rsp_valid}, 32'd1);
      check(!req_ready, "R7 not ready while responding", {31'd0, req_ready}, 32'd0);
      if (dbad) begin
        check(rsp_fault && !rsp_fault_lvl, "R5 directory fault level", {30'd0, rsp_fault, rsp_fault_lvl}, 32'd2);
        check(rsp_paddr == 0, "R5 fault paddr zero", rsp_paddr, 32'd0);
      end else if (pbad) begin
        check(rsp_fault && rsp_fault_lvl, "R6 table fault level", {30'd0, rsp_fault, rsp_fault_lvl}, 32'd3);
        check(rsp_paddr == 0, "R6 fault paddr zero", rsp_paddr, 32'd0);
      end else begin
        check(!rsp_fault, "R4 no fault", {31'd0, rsp_fault}, 32'd0);
        check(rsp_paddr == e_pa, "R4 physical address", rsp_paddr, e_pa);
      end
      rsp_ready = (($urandom % 3) != 0);
      if (rsp_ready) begin
        req_valid = 0;
        @(negedge clk);
        rsp_ready = 0;
        break;
      end
      @(negedge clk);
    end
    check(!rsp_valid && req_ready, "R10 released after handshake", {30'd0, rsp_valid, req_ready}, 32'd1);
    check(rd_count == e_reads, dbad ? "R5 read count" : "R6 read count", rd_count, e_reads);
    check(rd_log[0] == e_dir_addr, "R2 directory read address (R8 root sampled)", rd_log[0], e_dir_addr);
    if (!dbad)
      check(rd_log[1] == e_pte_addr, "R3 table read address", rd_log[1], e_pte_addr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired act=%h exp=%h", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; req_valid = 0; req_vaddr = '0; table_root = '0; rsp_ready = 0;
    dir_bad = 0; pte_bad = 0;
    repeat (3) @(negedge clk);
    check(req_ready && !rsp_valid && !mem_rd_valid, "R1 state in reset",
          {29'd0, req_ready, rsp_valid, mem_rd_valid}, 32'd4);
    rst_n = 1;
    @(negedge clk);
    check(req_ready && !rsp_valid && !mem_rd_valid, "R1 state after reset",
          {29'd0, req_ready, rsp_valid, mem_rd_valid}, 32'd4);

    run_walk(32'h0000_0000, 32'h0010_0000, 0, 0, 0);
    run_walk(32'hFFFF_FFFF, 32'h0020_0000, 0, 0, 0);
    run_walk(32'h1234_5678, 32'h0000_3004, 1, 0, 0);
    run_walk(32'h8765_4321, 32'h0040_0000, 0, 1, 0);
    run_walk(32'hABCD_E123, 32'h0050_0000, 0, 0, 1);
    run_walk(32'hFFC0_0FFF, 32'hFFFF_F000, 0, 0, 0);
    for (int i = 0; i < 60; i++) begin
      bit db, pb;
      db = (($urandom % 8) == 0);
      pb = (($urandom % 8) == 0);
      run_walk($urandom, $urandom, db, pb, (($urandom % 4) == 0));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule